// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR-style flash device. It samples the bus strobes on a system clock and turns each qualified write strobe into one write event. It follows the unlock handshakes that guard every change to the array. Complete sequences become one-cycle requests to a storage back end: program one location, erase one sector, or erase the whole chip. The back end reports a busy flag, and the decoder ignores the bus while that flag is high.

Two query modes change what a read returns: a product-identification mode and a parameter-query mode. The decoder selects the read source through `readSel`. It enters each mode with its own three-write sequence, and only an explicit exit write leaves it. A low level on the write-protect pin blocks requests that would alter the 64 KByte boot block. A parameter places that block at the bottom or the top of the address space. Any write that breaks a sequence, and any reset, returns the decoder to plain array reads. An interrupted operation is never resumed.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write event occurs on the first clock at which `ceN`=0, `weN`=0 and `oeN`=1 hold together after a clock at which they did not. A strobe held for many clocks yields one event. Strobes with `oeN` low or `ceN` high are not decoded.
- R2: A program request needs three writes: data AAh to word address AAAh, then 55h to 555h, then A0h to AAAh. The next write event then raises `reqValid` for exactly one clock, starting the clock after that event, with `reqOp`=2'b01 and that write's address on `reqAddr` and data on `reqData`. The decoder then returns to array reads.
- R3: An erase needs six writes: AAh@AAAh, 55h@555h, 80h@AAAh, AAh@AAAh, 55h@555h, then a final command. A final 30h at any address requests a sector erase (`reqOp`=2'b10, `reqAddr`=that address). A final 10h at AAAh requests a chip erase (`reqOp`=2'b11).
- R4: The sequence AAh@AAAh, 55h@555h, 90h@AAAh selects the identification source (`readSel`=2'b01) from the clock after the third event. Other writes leave the mode unchanged. A write with data F0h restores `readSel`=2'b00.
- R5: The same sequence ending in 98h@AAAh selects the query source (`readSel`=2'b10). The decoder stays in that mode, ignoring unlock and command writes, until a write with data F0h restores `readSel`=2'b00. `readSel` never takes the value 2'b11.
- R6: A write event that does not match the next expected step of a sequence aborts it. The decoder returns to array reads, issues no request, and the aborting write does not start a new sequence.
- R7: While `beBusy` is high, write events are discarded. No request is issued and neither the sequence position nor the read source changes.
- R8: With `wpN` low, a program or sector erase whose address lies in the boot block is suppressed, and so is every chip erase. The boot block is address bits [20:16] all zero in the default bottom placement. With `wpN` high, or for addresses outside the block, such requests are issued normally.
- R9: `rstN` low clears `reqValid`, sets `readSel`=2'b00 and discards any partial sequence. An interrupted sequence must be started again from the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 21 | Bus address |
| busData | input | 8 | Bus write data |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| wpN | input | 1 | Boot block write protect, active low |
| beBusy | input | 1 | Back end busy with an operation |
| reqValid | output | 1 | One-clock request strobe to the back end |
| reqOp | output | 2 | Request kind: 01 program, 10 sector erase, 11 chip erase, 00 none |
| reqAddr | output | 21 | Target address of the last request |
| reqData | output | 8 | Program data of the last request |
| readSel | output | 2 | Read source: 00 array, 01 identification, 10 query |

## Verification
A wrong sequence position shows up at the ports on the first write event after the fault. If the decoder has slipped forward, a request appears where the reference expects none. If it has dropped back, an expected request never arrives. If it is stuck in a query mode, `readSel` differs on the very next clock. Protection faults only show when a request to the boot block completes, so the bench drives protected and unprotected targets with `wpN` at both levels. The bench compares request strobe, kind, address, data and read source against a behavioural model on every clock, so each divergence is reported one clock after it starts.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_SECT = 2'b10,
    OP_CHIP = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'b00,
    SRC_ID    = 2'b01,
    SRC_QUERY = 2'b10
  } src_e;

  // Decoded view of the current bus cycle, datapath -> control
  typedef struct packed {
    logic wrEvt;
    logic isUnl1;
    logic isUnl2;
    logic cmdProg;
    logic cmdErase;
    logic cmdId;
    logic cmdQuery;
    logic cmdSector;
    logic cmdChip;
    logic cmdExit;
    logic protHit;
    logic wpLow;
  } flags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic issue;
    op_e  op;
  } strobes_t;

endpackage

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 21,
  parameter int unsigned BOOT_W   = 16,
  parameter bit          BOOT_TOP = 1'b0,
  parameter int unsigned UNL_A1   = 'hAAA,
  parameter int unsigned UNL_A2   = 'h555,
  parameter logic [7:0]  CMD_PROG  = 8'hA0,
  parameter logic [7:0]  CMD_ERASE = 8'h80,
  parameter logic [7:0]  CMD_SECT  = 8'h30,
  parameter logic [7:0]  CMD_CHIP  = 8'h10,
  parameter logic [7:0]  CMD_ID    = 8'h90,
  parameter logic [7:0]  CMD_QUERY = 8'h98,
  parameter logic [7:0]  CMD_EXIT  = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busData,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              wpN,
  input  logic              beBusy,
  input  strobes_t          strobes,
  output flags_t            flags,
  output logic              reqValid,
  output op_e               reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData
);

  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNL_A1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNL_A2);
  localparam int unsigned HI_W = ADDR_W - BOOT_W;

  logic wrActive;
  logic wrPrev;
  logic atA1;
  logic atA2;
  logic inBoot;
  logic [HI_W-1:0] addrHi;

  assign wrActive = ~ceN & ~weN & oeN;
  assign atA1     = (busAddr == A1);
  assign atA2     = (busAddr == A2);
  assign addrHi   = busAddr[ADDR_W-1:BOOT_W];

  generate
    if (BOOT_TOP) begin : g_bootTop
      assign inBoot = &addrHi;
    end else begin : g_bootBottom
      assign inBoot = ~|addrHi;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPrev <= 1'b0;
    else       wrPrev <= wrActive;
  end

  always_comb begin
    flags.wrEvt     = wrActive & ~wrPrev & ~beBusy;
    flags.isUnl1    = atA1 & (busData == 8'hAA);
    flags.isUnl2    = atA2 & (busData == 8'h55);
    flags.cmdProg   = atA1 & (busData == CMD_PROG);
    flags.cmdErase  = atA1 & (busData == CMD_ERASE);
    flags.cmdId     = atA1 & (busData == CMD_ID);
    flags.cmdQuery  = atA1 & (busData == CMD_QUERY);
    flags.cmdSector = (busData == CMD_SECT);
    flags.cmdChip   = atA1 & (busData == CMD_CHIP);
    flags.cmdExit   = (busData == CMD_EXIT);
    flags.protHit   = inBoot & ~wpN;
    flags.wpLow     = ~wpN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      reqOp    <= OP_NONE;
      reqAddr  <= '0;
      reqData  <= '0;
    end else if (strobes.issue) begin
      reqValid <= 1'b1;
      reqOp    <= strobes.op;
      reqAddr  <= busAddr;
      reqData  <= busData;
    end else begin
      reqValid <= 1'b0;
      reqOp    <= OP_NONE;
    end
  end

endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  flags_t   flags,
  output strobes_t strobes,
  output src_e     readSel
);

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_ERS1,
    ST_ERS2,
    ST_ERS3,
    ST_ID,
    ST_QUERY
  } state_e;

  state_e st, stNext;

  always_comb begin
    stNext        = st;
    strobes.issue = 1'b0;
    strobes.op    = OP_NONE;
    if (flags.wrEvt) begin
      unique case (st)
        ST_READ: stNext = flags.isUnl1 ? ST_UNL1 : ST_READ;
        ST_UNL1: stNext = flags.isUnl2 ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          if (flags.cmdProg)       stNext = ST_PROG;
          else if (flags.cmdErase) stNext = ST_ERS1;
          else if (flags.cmdId)    stNext = ST_ID;
          else if (flags.cmdQuery) stNext = ST_QUERY;
          else                     stNext = ST_READ;
        end
        ST_PROG: begin
          stNext        = ST_READ;
          strobes.issue = ~flags.protHit;
          strobes.op    = OP_PROG;
        end
        ST_ERS1: stNext = flags.isUnl1 ? ST_ERS2 : ST_READ;
        ST_ERS2: stNext = flags.isUnl2 ? ST_ERS3 : ST_READ;
        ST_ERS3: begin
          stNext = ST_READ;
          if (flags.cmdChip) begin
            strobes.issue = ~flags.wpLow;
            strobes.op    = OP_CHIP;
          end else if (flags.cmdSector) begin
            strobes.issue = ~flags.protHit;
            strobes.op    = OP_SECT;
          end
        end
        ST_ID:    stNext = flags.cmdExit ? ST_READ : ST_ID;
        ST_QUERY: stNext = flags.cmdExit ? ST_READ : ST_QUERY;
        default:  stNext = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_READ;
    else       st <= stNext;
  end

  always_comb begin
    unique case (st)
      ST_ID:    readSel = SRC_ID;
      ST_QUERY: readSel = SRC_QUERY;
      default:  readSel = SRC_ARRAY;
    endcase
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 21,
  parameter int unsigned BOOT_W   = 16,
  parameter bit          BOOT_TOP = 1'b0,
  parameter int unsigned UNL_A1   = 'hAAA,
  parameter int unsigned UNL_A2   = 'h555,
  parameter logic [7:0]  CMD_PROG  = 8'hA0,
  parameter logic [7:0]  CMD_ERASE = 8'h80,
  parameter logic [7:0]  CMD_SECT  = 8'h30,
  parameter logic [7:0]  CMD_CHIP  = 8'h10,
  parameter logic [7:0]  CMD_ID    = 8'h90,
  parameter logic [7:0]  CMD_QUERY = 8'h98,
  parameter logic [7:0]  CMD_EXIT  = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busData,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              wpN,
  input  logic              beBusy,
  output logic              reqValid,
  output logic [1:0]        reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData,
  output logic [1:0]        readSel
);

  flags_t   flags;
  strobes_t strobes;
  op_e      opQ;
  src_e     srcQ;

  fcd_datapath #(
    .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .BOOT_TOP(BOOT_TOP),
    .UNL_A1(UNL_A1), .UNL_A2(UNL_A2),
    .CMD_PROG(CMD_PROG), .CMD_ERASE(CMD_ERASE), .CMD_SECT(CMD_SECT),
    .CMD_CHIP(CMD_CHIP), .CMD_ID(CMD_ID), .CMD_QUERY(CMD_QUERY),
    .CMD_EXIT(CMD_EXIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData),
    .ceN(ceN), .weN(weN), .oeN(oeN), .wpN(wpN), .beBusy(beBusy),
    .strobes(strobes), .flags(flags),
    .reqValid(reqValid), .reqOp(opQ), .reqAddr(reqAddr), .reqData(reqData)
  );

  fcd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .flags(flags),
    .strobes(strobes), .readSel(srcQ)
  );

  assign reqOp   = opQ;
  assign readSel = srcQ;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int unsigned ADDR_W   = 21,
  parameter int unsigned BOOT_W   = 16,
  parameter bit          BOOT_TOP = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              weN,
  input logic              oeN,
  input logic              wpN,
  input logic              beBusy,
  input logic              reqValid,
  input logic [1:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        readSel
);

  logic reqInBoot;
  assign reqInBoot = BOOT_TOP ? (reqAddr[ADDR_W-1:BOOT_W] == {(ADDR_W-BOOT_W){1'b1}})
                              : (reqAddr[ADDR_W-1:BOOT_W] == '0);

  AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $past(!ceN && !weN && oeN)); // R1

  AST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid); // R2

  AST_REQ_HAS_OP: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqOp != 2'b00)); // R3

  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    readSel != 2'b11); // R5

  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !$past(beBusy)); // R7

  AST_PROT_BOOT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp != 2'b11 && reqInBoot) |-> $past(wpN)); // R8

  AST_PROT_CHIP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b11) |-> $past(wpN)); // R8

endmodule

bind flash_cmd_decoder fcd_checker #(
  .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .BOOT_TOP(BOOT_TOP)
) u_chk (.*);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;

  localparam int AW = 21;
  localparam logic [AW-1:0] UA = 21'hAAA;
  localparam logic [AW-1:0] UB = 21'h555;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [7:0]    busData = '0;
  logic          ceN = 1'b1, weN = 1'b1, oeN = 1'b1, wpN = 1'b1, beBusy = 1'b0;
  logic          reqValid;
  logic [1:0]    reqOp;
  logic [AW-1:0] reqAddr;
  logic [7:0]    reqData;
  logic [1:0]    readSel;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData),
    .ceN(ceN), .weN(weN), .oeN(oeN), .wpN(wpN), .beBusy(beBusy),
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .readSel(readSel)
  );

  int total = 0;
  int bad = 0;
  string curTag = "R9";
  bit done = 1'b0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: 0 read,1-2 unlock,3 program data,4-6 erase steps,7 id,8 query
  int            mSt = 0;
  bit            mPrev = 0;
  bit            mValid = 0;
  int            mOp = 0;
  logic [AW-1:0] mAddr = '0;
  logic [7:0]    mData = '0;

  function automatic bit inBootM(input logic [AW-1:0] a);
    return (a >> 16) == 0;
  endfunction

  always @(posedge clk) begin
    bit act, evt;
    if (!rstN) begin
      mSt = 0; mPrev = 0; mValid = 0; mOp = 0; mAddr = '0; mData = '0;
    end else begin
      act = !ceN && !weN && oeN;
      evt = act && !mPrev && !beBusy;
      mPrev = act;
      mValid = 0; mOp = 0;
      if (evt) begin
        case (mSt)
          0: mSt = (busAddr == UA && busData == 8'hAA) ? 1 : 0;
          1: mSt = (busAddr == UB && busData == 8'h55) ? 2 : 0;
          2: begin
            if (busAddr != UA) mSt = 0;
            else if (busData == 8'hA0) mSt = 3;
            else if (busData == 8'h80) mSt = 4;
            else if (busData == 8'h90) mSt = 7;
            else if (busData == 8'h98) mSt = 8;
            else mSt = 0;
          end
          3: begin
            mSt = 0;
            if (!(inBootM(busAddr) && !wpN)) begin
              mValid = 1; mOp = 1; mAddr = busAddr; mData = busData;
            end
          end
          4: mSt = (busAddr == UA && busData == 8'hAA) ? 5 : 0;
          5: mSt = (busAddr == UB && busData == 8'h55) ? 6 : 0;
          6: begin
            mSt = 0;
            if (busAddr == UA && busData == 8'h10) begin
              if (wpN) begin mValid = 1; mOp = 3; mAddr = busAddr; mData = busData; end
            end else if (busData == 8'h30) begin
              if (!(inBootM(busAddr) && !wpN)) begin
                mValid = 1; mOp = 2; mAddr = busAddr; mData = busData;
              end
            end
          end
          7, 8: if (busData == 8'hF0) mSt = 0;
          default: mSt = 0;
        endcase
      end
    end
  end

  int reqCount = 0;
  int lastOp = 0;
  logic [AW-1:0] lastAddr = '0;
  logic [7:0] lastData = '0;

  always @(negedge clk) begin
    if (!done) begin
      chk(curTag, "reqValid", reqValid, mValid);
      chk(curTag, "reqOp", reqOp, mOp);
      chk(curTag, "reqAddr", reqAddr, mAddr);
      chk(curTag, "readSel", readSel, (mSt == 7) ? 1 : (mSt == 8) ? 2 : 0);
      if (mValid) chk(curTag, "reqData", reqData, mData);
      if (reqValid) begin
        reqCount++; lastOp = reqOp; lastAddr = reqAddr; lastData = reqData;
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input bit oeLow = 0, input bit ceHigh = 0, input int hold = 1);
    @(negedge clk);
    busAddr = a; busData = d; ceN = ceHigh; weN = 1'b0; oeN = !oeLow;
    repeat (hold) @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock3(input logic [7:0] cmd);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, cmd);
  endtask

  task automatic eraseSeq(input logic [AW-1:0] a, input logic [7:0] d);
    unlock3(8'h80); wr(UA, 8'hAA); wr(UB, 8'h55); wr(a, d);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    curTag = "R9";
    chk("R9", "reset readSel", readSel, 0);
    chk("R9", "reset reqValid", reqValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    curTag = "R2"; c0 = reqCount;
    unlock3(8'hA0); wr(21'h1F0010, 8'h5A);
    chk("R2", "program count", reqCount - c0, 1);
    chk("R2", "program op", lastOp, 1);
    chk("R2", "program addr", lastAddr, 21'h1F0010);
    chk("R2", "program data", lastData, 8'h5A);

    curTag = "R3"; c0 = reqCount;
    eraseSeq(21'h120000, 8'h30);
    chk("R3", "sector op", lastOp, 2);
    chk("R3", "sector addr", lastAddr, 21'h120000);
    eraseSeq(UA, 8'h10);
    chk("R3", "chip op", lastOp, 3);
    chk("R3", "erase count", reqCount - c0, 2);

    curTag = "R8"; wpN = 1'b0; c0 = reqCount;
    unlock3(8'hA0); wr(21'h000100, 8'h11);
    chk("R8", "protected program suppressed", reqCount - c0, 0);
    eraseSeq(21'h00F000, 8'h30);
    eraseSeq(UA, 8'h10);
    chk("R8", "protected erases suppressed", reqCount - c0, 0);
    unlock3(8'hA0); wr(21'h100000, 8'h22);
    chk("R8", "outside block allowed", reqCount - c0, 1);
    wpN = 1'b1;
    unlock3(8'hA0); wr(21'h000100, 8'h33);
    chk("R8", "unprotected boot program", lastAddr, 21'h000100);
    chk("R8", "total with wp toggled", reqCount - c0, 2);

    curTag = "R4";
    unlock3(8'h90);
    chk("R4", "id mode", readSel, 1);
    wr(UA, 8'hAA);
    chk("R4", "id mode kept", readSel, 1);
    wr(21'h000007, 8'hF0);
    chk("R4", "id exit", readSel, 0);

    curTag = "R5"; c0 = reqCount;
    unlock3(8'h98);
    chk("R5", "query mode", readSel, 2);
    unlock3(8'hA0); wr(21'h1F0000, 8'h44);
    chk("R5", "query ignores program", reqCount - c0, 0);
    chk("R5", "query mode kept", readSel, 2);
    wr(UB, 8'hF0);
    chk("R5", "query exit", readSel, 0);

    curTag = "R6"; c0 = reqCount;
    wr(UA, 8'hAA); wr(UB, 8'h98); wr(UA, 8'h98);
    chk("R6", "query with wrong address aborted", readSel, 0);
    wr(UA, 8'hAA); wr(UB, 8'h56); wr(UA, 8'hA0); wr(21'h1F0000, 8'h55);
    chk("R6", "corrupt unlock no request", reqCount - c0, 0);
    unlock3(8'h80); wr(UA, 8'hAA); wr(UA, 8'h55); wr(21'h1F0000, 8'h30);
    chk("R6", "corrupt erase no request", reqCount - c0, 0);

    curTag = "R1"; c0 = reqCount;
    unlock3(8'hA0);
    wr(21'h1F0001, 8'h01, 1'b1, 1'b0);
    wr(21'h1F0002, 8'h02, 1'b0, 1'b1);
    chk("R1", "undecoded strobes ignored", reqCount - c0, 0);
    wr(21'h1F0003, 8'h03, 1'b0, 1'b0, 6);
    chk("R1", "held strobe one request", reqCount - c0, 1);
    chk("R1", "request addr after ignored cycles", lastAddr, 21'h1F0003);

    curTag = "R7"; c0 = reqCount;
    beBusy = 1'b1;
    unlock3(8'h90);
    chk("R7", "busy blocks mode entry", readSel, 0);
    unlock3(8'hA0); wr(21'h1F0004, 8'h04);
    chk("R7", "busy blocks request", reqCount - c0, 0);
    beBusy = 1'b0;
    wr(21'h1F0005, 8'h05);
    chk("R7", "sequence not tracked while busy", reqCount - c0, 0);

    curTag = "R9"; c0 = reqCount;
    wr(UA, 8'hAA); wr(UB, 8'h55);
    @(negedge clk); rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
    wr(UA, 8'hA0); wr(21'h1F0006, 8'h06);
    chk("R9", "partial sequence discarded", reqCount - c0, 0);
    unlock3(8'h98);
    @(negedge clk); rstN = 1'b0; @(negedge clk);
    chk("R9", "reset leaves query mode", readSel, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule